// File: doc/BRIEF.md
# Retrace-Gated Video Write Queue

This block lets a processor update video memory without ever taking the memory away from the pixel fetch path during visible scan-out. Each processor store aimed at the video window is captured as an address and value pair in a small queue. The queue has separate clocks for its two sides. The processor side fills the queue at any moment. The pixel side empties it only while the display timing reports a retrace interval.

While blanking is reported, the pixel side issues one video RAM write per pixel clock until the queue runs dry or blanking ends. A burst that is cut short by the start of visible video picks up again at the next retrace. The RAM is only written during intervals where nothing is being displayed, so the picture shows no artefacts from processor traffic.

Pointers cross between the clock domains in Gray code through two-flop synchronisers. A store that arrives while the queue is full is discarded. The discard sets a sticky overflow flag that only a reset clears.

Top module: `vbw_top`

## Requirements
- R1: After reset, `ram_we`, `fifo_full` and `overflow` are all 0.
- R2: Every accepted processor store appears exactly once on the video RAM port, with `ram_addr` equal to the stored `cpu_addr` and `ram_data` equal to the stored `cpu_data`.
- R3: Accepted stores reach the video RAM port in the order the processor issued them.
- R4: `ram_we` is high in a pixel cycle only if `blank` was high at the pixel clock edge that launched that write.
- R5: While `blank` stays high and the queue holds entries that are already visible to the pixel side, one write is issued on every pixel clock with no idle cycles.
- R6: When `blank` falls, writing stops at the first pixel edge that samples it low. Entries that remain are written at the next blanking interval.
- R7: `fifo_full` is 1 when DEPTH accepted stores are waiting and none has been drained. It is 0 when fewer are waiting and the pixel side's progress has become visible to the processor side.
- R8: A store issued while `fifo_full` is 1 is dropped and never reaches the RAM port. It sets `overflow`, which then stays 1 until reset.
- R9: Stores are accepted whatever the state of `blank`, including while a burst is in progress.
- R10: Each Gray-coded queue pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst_n | input | 1 | Processor-side synchronous reset, active low |
| cpu_wr | input | 1 | Store strobe for the video window, one entry per cycle while high |
| cpu_addr | input | ADDR_W | Target pixel address of the store |
| cpu_data | input | DATA_W | Pixel value of the store |
| fifo_full | output | 1 | Queue cannot accept a store this cycle |
| overflow | output | 1 | Sticky: a store was dropped because the queue was full |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-side synchronous reset, active low |
| blank | input | 1 | High during horizontal or vertical retrace |
| ram_we | output | 1 | Video RAM write enable |
| ram_addr | output | ADDR_W | Video RAM write address |
| ram_data | output | DATA_W | Video RAM write data |

## Verification
The assertions assume that each reset is held for at least one edge of its own clock and that `blank` and the store inputs are synchronous to their own domains. The bench drives `blank` just after a falling pixel edge and drives the store strobe just after a falling processor edge, so every input is stable around the rising edge that samples it. The bench waits for pointer synchronisation to settle before it judges `fifo_full` or the burst spacing. This matters because both signals are deliberately pessimistic while a pointer is still crossing between the clock domains.

// File: rtl/vbw_pkg.sv
// Package: shared helpers for the retrace-gated write queue.
// Assumes pointer widths of at least two bits.
package vbw_pkg;

    // Convert a binary pointer value to its reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/vbw_sync.sv
// Module: two-stage synchroniser for a Gray-coded pointer bus.
// Assumes the input changes by at most one bit per source clock, so that
// any sampled value is either the old or the new pointer.
module vbw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series absorb metastability from the other domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/vbw_push.sv
// Module: processor-side write pointer, full detection and overflow flag.
// Assumes rgray_s is the pixel-side read pointer already synchronised into
// this clock domain; full is therefore conservative, never optimistic.
module vbw_push #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PTR_W-1:0] rgray_s,
    output logic             full,
    output logic             overflow,
    output logic             mem_we,
    output logic [PTR_W-2:0] waddr,
    output logic [PTR_W-1:0] wgray
);
    import vbw_pkg::*;

    localparam logic [PTR_W-1:0] TOP2 = PTR_W'(3) << (PTR_W - 2);

    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nxt;
    logic [31:0]      gray_nxt;

    // Full when write pointer is one lap ahead of the synchronised read pointer.
    always_comb begin
        full     = (wgray == (rgray_s ^ TOP2));
        mem_we   = wr && !full;
        waddr    = wbin[PTR_W-2:0];
        wbin_nxt = wbin + PTR_W'(1);
        gray_nxt = bin2gray(32'(wbin_nxt));
    end

    // Advance pointer on accepted stores; latch overflow on a dropped store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            if (mem_we) begin
                wbin  <= wbin_nxt;
                wgray <= gray_nxt[PTR_W-1:0];
            end
            if (wr && full) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R10
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |=> $stable(wgray)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
endmodule

// File: rtl/vbw_pop.sv
// Module: pixel-side read pointer and drain gating.
// Assumes wgray_s is the processor-side write pointer synchronised into
// the pixel domain; empty is therefore conservative.
module vbw_pop #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank,
    input  logic [PTR_W-1:0] wgray_s,
    output logic             pop,
    output logic [PTR_W-2:0] raddr,
    output logic [PTR_W-1:0] rgray
);
    import vbw_pkg::*;

    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] rbin_nxt;
    logic [31:0]      gray_nxt;
    logic             empty;

    // Drain only during retrace and only when an entry is visible.
    always_comb begin
        empty    = (rgray == wgray_s);
        pop      = blank && !empty;
        raddr    = rbin[PTR_W-2:0];
        rbin_nxt = rbin + PTR_W'(1);
        gray_nxt = bin2gray(32'(rbin_nxt));
    end

    // Advance the read pointer once per drained entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= gray_nxt[PTR_W-1:0];
        end
    end

    AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R10
endmodule

// File: rtl/vbw_top.sv
// Module: retrace-gated video write queue.
// Processor stores are queued as address/value pairs in cpu_clk and written
// to video RAM in pix_clk only while blank is high, one per pixel clock.
// Assumes each reset is held for at least one edge of its own clock.
module vbw_top #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 4
) (
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              fifo_full,
    output logic              overflow,
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    input  logic              blank,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_data
);
    localparam int DEPTH   = 1 << DEPTH_LOG2;
    localparam int PTR_W   = DEPTH_LOG2 + 1;
    localparam int ENTRY_W = ADDR_W + DATA_W;

    logic [ENTRY_W-1:0]   store [DEPTH];
    logic                 mem_we;
    logic [PTR_W-2:0]     waddr;
    logic [PTR_W-2:0]     raddr;
    logic [PTR_W-1:0]     wgray, wgray_s;
    logic [PTR_W-1:0]     rgray, rgray_s;
    logic                 pop;
    logic [ENTRY_W-1:0]   head;

    vbw_push #(.PTR_W(PTR_W)) u_push (
        .clk      (cpu_clk),
        .rst_n    (cpu_rst_n),
        .wr       (cpu_wr),
        .rgray_s  (rgray_s),
        .full     (fifo_full),
        .overflow (overflow),
        .mem_we   (mem_we),
        .waddr    (waddr),
        .wgray    (wgray)
    );

    vbw_sync #(.W(PTR_W)) u_sync_r2w (
        .clk   (cpu_clk),
        .rst_n (cpu_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    vbw_sync #(.W(PTR_W)) u_sync_w2r (
        .clk   (pix_clk),
        .rst_n (pix_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    vbw_pop #(.PTR_W(PTR_W)) u_pop (
        .clk     (pix_clk),
        .rst_n   (pix_rst_n),
        .blank   (blank),
        .wgray_s (wgray_s),
        .pop     (pop),
        .raddr   (raddr),
        .rgray   (rgray)
    );

    // Capture the address/value pair of each accepted store.
    always_ff @(posedge cpu_clk) begin
        if (mem_we) begin
            store[waddr] <= {cpu_addr, cpu_data};
        end
    end

    // Present the oldest entry to the output register.
    always_comb begin
        head = store[raddr];
    end

    // Register the video RAM write port in the pixel domain.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= pop;
            if (pop) begin
                ram_addr <= head[ENTRY_W-1:DATA_W];
                ram_data <= head[DATA_W-1:0];
            end
        end
    end

    AST_NO_WRITE_ACTIVE: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        ram_we |-> $past(blank)); // R4
    AST_STOP_ON_UNBLANK: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        !blank |=> !ram_we); // R6
endmodule

// File: tb/vbw_top_test.sv
module vbw_top_test;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int DL = 2;
    localparam int DEPTH = 1 << DL;

    logic cpu_clk = 0, pix_clk = 0;
    logic cpu_rst_n = 0, pix_rst_n = 0;
    logic cpu_wr = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_data = '0;
    logic fifo_full, overflow, blank = 0, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_data;

    int checks = 0, failures = 0;
    bit done = 0;
    int exp_w [64];
    int got_w [64];
    int got_c [64];
    int n_exp = 0, n_got = 0, pcyc = 0, active_wr = 0;

    vbw_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH_LOG2(DL)) uut (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .fifo_full(fifo_full),
        .overflow(overflow), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
        .blank(blank), .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    always #2.5 cpu_clk = ~cpu_clk;
    always #3.5 pix_clk = ~pix_clk;

    // Monitor the RAM port away from the rising pixel edge.
    always @(negedge pix_clk) begin
        pcyc = pcyc + 1;
        if (ram_we) begin
            if (!blank) active_wr = active_wr + 1;
            if (n_got < 64) begin
                got_w[n_got] = {16'd0, ram_addr, ram_data};
                got_c[n_got] = pcyc;
            end
            n_got = n_got + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int a, input int d, input bit accept);
        @(negedge cpu_clk);
        cpu_wr = 1; cpu_addr = AW'(a); cpu_data = DW'(d);
        @(negedge cpu_clk);
        cpu_wr = 0;
        if (accept) begin
            exp_w[n_exp] = {16'd0, 8'(a), 8'(d)};
            n_exp = n_exp + 1;
        end
    endtask

    task automatic wait_pix(input int n);
        for (int i = 0; i < n; i++) @(negedge pix_clk);
    endtask

    task automatic set_blank(input logic v);
        @(negedge pix_clk);
        #1 blank = v;
    endtask

    task automatic compare_all(input string req);
        chk(n_got == n_exp, req, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            chk(got_w[i] == exp_w[i], req, got_w[i], exp_w[i]);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_pix(4);
        cpu_rst_n = 1; pix_rst_n = 1;
        wait_pix(1);
        // R1: reset state
        chk(ram_we == 0, "R1 ram_we", ram_we, 0);
        chk(fifo_full == 0, "R1 fifo_full", fifo_full, 0);
        chk(overflow == 0, "R1 overflow", overflow, 0);

        // Sweep burst lengths 1..DEPTH, queued during active video.
        for (int n = 1; n <= DEPTH; n++) begin
            int start;
            start = n_got;
            for (int i = 0; i < n; i++) begin
                int a;
                a = (n * 37 + i * 11) & 255;
                push(a, (~a ^ (i * 3)) & 255, 1);
            end
            wait_pix(12);
            chk(n_got == start, "R4 held while active", n_got, start);
            chk(fifo_full == (n == DEPTH), "R7 full flag", fifo_full, n == DEPTH);
            set_blank(1);
            wait_pix(12);
            set_blank(0);
            wait_pix(4);
            chk(fifo_full == 0, "R7 full clears", fifo_full, 0);
            chk(n_got - start == n, "R2 count", n_got - start, n);
            chk(got_c[start + n - 1] - got_c[start] == n - 1, "R5 back to back",
                got_c[start + n - 1] - got_c[start], n - 1);
        end
        compare_all("R3 order and values");

        // R8: store into a full queue is dropped.
        for (int i = 0; i < DEPTH; i++) push(8'h40 + i, 8'h90 + i, 1);
        wait_pix(12);
        chk(fifo_full == 1, "R7 full", fifo_full, 1);
        push(8'hEE, 8'hEE, 0);
        chk(overflow == 1, "R8 overflow set", overflow, 1);
        set_blank(1);
        wait_pix(12);
        set_blank(0);
        wait_pix(4);
        compare_all("R8 dropped store absent");
        chk(overflow == 1, "R8 overflow sticky", overflow, 1);

        // R6: short retrace drains two entries, rest resume later.
        begin
            int start;
            for (int i = 0; i < DEPTH; i++) push(8'h60 + i, 8'hA0 + i, 1);
            wait_pix(12);
            start = n_got;
            set_blank(1);
            @(negedge pix_clk);
            @(negedge pix_clk);
            #1 blank = 0;
            wait_pix(8);
            chk(n_got - start == 2, "R6 partial stop", n_got - start, 2);
            set_blank(1);
            wait_pix(12);
            set_blank(0);
            wait_pix(4);
            chk(n_got - start == DEPTH, "R6 resumed", n_got - start, DEPTH);
            compare_all("R6 order after resume");
        end

        // R9: stores issued during retrace are still accepted and drained.
        set_blank(1);
        push(8'h11, 8'h22, 1);
        push(8'h33, 8'h44, 1);
        push(8'h55, 8'h66, 1);
        wait_pix(12);
        set_blank(0);
        wait_pix(4);
        compare_all("R9 stores during blank");

        chk(active_wr == 0, "R4 no write while active", active_wr, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule